// File: doc/BRIEF.md
# Bit-Flag Execute Unit

This block is the execute stage for a family of single-bit instructions in a small 32-bit processor core. Each cycle it may accept one 32-bit instruction word. It holds a 512-entry register file and two condition flags, carry (C) and zero (Z). The word names a destination register, a bit index and an operation. When the instruction's two flag-write bits are both clear, the unit rewrites one bit of the destination register. The new bit is a constant, a copy of a flag or of its inverse, the inverse of the old bit, or a pseudo-random bit.

When either flag-write bit is set, the same opcode takes a different path. The register is left alone, and the selected bit is folded into C, Z or both with an AND, OR or XOR, or it is simply loaded. A chain of such instructions evaluates a Boolean expression of register bits with the flags as accumulators, and it needs no branches. Every instruction first tests a 4-bit condition against the current flags. A failing condition turns the instruction into a no-op.

Other units read the register file through a combinational auxiliary port. Instruction fetch, other opcode groups, pins and memory are outside this block.

Top module: `bitflag_exec`

## Requirements
- R1: The instruction word is laid out, from bit 31 down, as condition [31:28], opcode [27:21], C-write [20], Z-write [19], immediate [18], destination [17:9] and source [8:0]. Only opcodes whose upper four bits are 0100 belong to the group. Any other opcode changes no register and no flag.
- R2: An instruction executes only when bit {C,Z} of the condition field is 1, with C as the upper index bit. So 0000 never executes, 1111 always executes, 1100 needs C, and 1000 needs C and Z together. When the condition fails, no register and no flag changes.
- R3: With both flag-write bits 0, the low three opcode bits 0 to 6 write the selected bit of the destination register. In order, the new bit is 0, 1, C, NOT C, Z, NOT Z, or the inverse of the old bit. All other bits of the register keep their values, and both flags keep their values.
- R4: With both flag-write bits 0, low opcode bits 7 write a random bit. This bit is bit 0 of a 16-bit LFSR that resets to 0xACE1. After each executed random write, the LFSR takes the new state {s[14:0], s[15]^s[13]^s[12]^s[10]}. No other instruction advances it.
- R5: With either flag-write bit set, the destination register is unchanged. Each enabled flag f receives a new value chosen by the low opcode bits from 0 to 7, in order: f AND b, f AND NOT b, f OR b, f OR NOT b, f XOR b, f XOR NOT b, b, NOT b. Here b is the selected register bit.
- R6: The complement in the odd flag operations applies to the register bit and never to the flag. When both flag-write bits are set, C and Z are each computed from their own previous value, using the same b and the same operation.
- R7: A flag whose write bit is 0 keeps its value through a flag-mode instruction.
- R8: With the immediate bit 1, the bit index is source[4:0]. With it 0, the index is bits [4:0] of the register the source field addresses. Higher bits are ignored in both cases.
- R9: After reset, C and Z are 0. Each instruction completes at the clock edge that samples it. The next instruction, issued back to back, sees the updated register and flags. With instr_valid low, nothing changes.
- R10: After reset, every register reads as zero on the auxiliary port. That port always returns the current contents of the register it addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Instruction word |
| aux_addr | input | 9 | Register address for the auxiliary read port |
| aux_data | output | 32 | Contents of the register at aux_addr |
| c_flag | output | 1 | Carry flag |
| z_flag | output | 1 | Zero flag |

## Verification
Internal faults show up at the ports one cycle after the instruction that reveals them, because flag updates and register writes both land at the sampling edge. A decode fault that picks the wrong operation, index or condition appears as a wrong flag or a wrong word in the next aux read. A wrong LFSR state stays hidden until the next executed random write. From then on the stored bit diverges from the independent sequence the bench keeps. A register write that lands at the wrong index, or a flag that should have held but changed, is caught at the next comparison against the bench model. The sweep crosses every condition code with every opcode, both flag-write bits and both index sources.

// File: rtl/bfx_pkg.sv
package bfx_pkg;

   localparam int INSTR_W = 32;
   localparam int FIELD_W = 9;
   localparam logic [3:0] GROUP_TAG = 4'b0100;

   // low opcode bits in register-write mode
   typedef enum logic [2:0] {
      OP_CLR  = 3'd0,
      OP_SET  = 3'd1,
      OP_CPC  = 3'd2,
      OP_CPNC = 3'd3,
      OP_CPZ  = 3'd4,
      OP_CPNZ = 3'd5,
      OP_INV  = 3'd6,
      OP_RND  = 3'd7
   } bop_e;

   typedef struct packed {
      logic [3:0]         cond;
      logic [6:0]         opcode;
      logic               wc;
      logic               wz;
      logic               imm;
      logic [FIELD_W-1:0] dst;
      logic [FIELD_W-1:0] src;
   } instr_t;

   // condition field is a truth table indexed by the flag pair
   function automatic logic cond_pass(logic [3:0] cond, logic c, logic z);
      return cond[{c, z}];
   endfunction

   // kind: 0 and, 1 or, 2 xor, 3 load
   function automatic logic fold(logic f, logic bv, logic [1:0] kind);
      case (kind)
         2'd0:    return f & bv;
         2'd1:    return f | bv;
         2'd2:    return f ^ bv;
         default: return bv;
      endcase
   endfunction

endpackage

// File: rtl/bfx_lfsr.sv
module bfx_lfsr #(
   parameter int             W    = 16,
   parameter logic [W-1:0]   SEED = 16'hACE1,
   parameter logic [W-1:0]   TAPS = 16'hB400
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   output logic         bit_out,
   output logic [W-1:0] state
);

   logic fb;

   generate
      if (W < 3) begin : g_bad_width
         $error("bfx_lfsr: width too small");
      end
      if (SEED == '0) begin : g_bad_seed
         $error("bfx_lfsr: seed must be nonzero");
      end
      if (!TAPS[W-1]) begin : g_bad_taps
         $error("bfx_lfsr: tap mask must include the top bit");
      end
   endgenerate

   assign fb      = ^(state & TAPS);
   assign bit_out = state[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    state <= SEED;
      else if (step) state <= {state[W-2:0], fb};
   end

endmodule

// File: rtl/bfx_regfile.sv
module bfx_regfile #(
   parameter int XLEN           = 32,
   parameter int NREG           = 512,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int AW            = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [AW-1:0]   waddr,
   input  logic [XLEN-1:0] wdata,
   input  logic [AW-1:0]   ra_addr,
   output logic [XLEN-1:0] ra_data,
   input  logic [AW-1:0]   rb_addr,
   output logic [XLEN-1:0] rb_data,
   input  logic [AW-1:0]   rc_addr,
   output logic [XLEN-1:0] rc_data
);

   logic [XLEN-1:0] mem [NREG];

   generate
      if (CLEAR_ON_RESET) begin : g_clear
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < NREG; i++) mem[i] <= '0;
            end else if (we) begin
               mem[waddr] <= wdata;
            end
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (we) mem[waddr] <= wdata;
         end
      end
   endgenerate

   assign ra_data = mem[ra_addr];
   assign rb_data = mem[rb_addr];
   assign rc_data = mem[rc_addr];

endmodule

// File: rtl/bfx_decode.sv
module bfx_decode
   import bfx_pkg::*;
(
   input  logic               instr_valid,
   input  instr_t             ins,
   input  logic               c,
   input  logic               z,
   output logic               exec,
   output logic               flag_mode,
   output logic               wc,
   output logic               wz,
   output logic               imm,
   output bop_e               op,
   output logic [FIELD_W-1:0] dst,
   output logic [FIELD_W-1:0] src
);

   logic in_group;
   logic pass;

   assign in_group  = (ins.opcode[6:3] == GROUP_TAG);
   assign pass      = cond_pass(ins.cond, c, z);
   assign exec      = instr_valid & in_group & pass;
   assign wc        = ins.wc;
   assign wz        = ins.wz;
   assign flag_mode = ins.wc | ins.wz;
   assign imm       = ins.imm;
   assign op        = bop_e'(ins.opcode[2:0]);
   assign dst       = ins.dst;
   assign src       = ins.src;

endmodule

// File: rtl/bfx_bitop.sv
module bfx_bitop
   import bfx_pkg::*;
#(
   parameter int  XLEN = 32,
   localparam int IW   = $clog2(XLEN)
) (
   input  bop_e            op,
   input  logic [XLEN-1:0] word,
   input  logic [IW-1:0]   idx,
   input  logic            c,
   input  logic            z,
   input  logic            rnd,
   output logic [XLEN-1:0] new_word,
   output logic            c_fold,
   output logic            z_fold
);

   logic cur;
   logic opnd;
   logic nbit;

   assign cur  = word[idx];
   // odd operations take the complement of the register bit, never of the flag
   assign opnd = op[0] ? ~cur : cur;

   assign c_fold = fold(c, opnd, op[2:1]);
   assign z_fold = fold(z, opnd, op[2:1]);

   always_comb begin
      case (op)
         OP_CLR:  nbit = 1'b0;
         OP_SET:  nbit = 1'b1;
         OP_CPC:  nbit = c;
         OP_CPNC: nbit = ~c;
         OP_CPZ:  nbit = z;
         OP_CPNZ: nbit = ~z;
         OP_INV:  nbit = ~cur;
         default: nbit = rnd;
      endcase
   end

   for (genvar j = 0; j < XLEN; j++) begin : g_bit
      assign new_word[j] = (idx == IW'(j)) ? nbit : word[j];
   end

endmodule

// File: rtl/bitflag_exec.sv
module bitflag_exec
   import bfx_pkg::*;
#(
   parameter int                XLEN           = 32,
   parameter int                NREG           = 512,
   parameter int                LFSR_W         = 16,
   parameter logic [LFSR_W-1:0] LFSR_SEED      = 16'hACE1,
   parameter logic [LFSR_W-1:0] LFSR_TAPS      = 16'hB400,
   parameter bit                CLEAR_ON_RESET = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    instr_valid,
   input  logic [INSTR_W-1:0]      instr,
   input  logic [$clog2(NREG)-1:0] aux_addr,
   output logic [XLEN-1:0]         aux_data,
   output logic                    c_flag,
   output logic                    z_flag
);

   localparam int AW = $clog2(NREG);
   localparam int IW = $clog2(XLEN);

   generate
      if (XLEN < 2 || XLEN > 512 || (XLEN & (XLEN - 1)) != 0) begin : g_bad_xlen
         $error("bitflag_exec: XLEN must be a power of two from 2 to 512");
      end
      if (NREG < 2 || NREG > 512 || (NREG & (NREG - 1)) != 0) begin : g_bad_nreg
         $error("bitflag_exec: NREG must be a power of two from 2 to 512");
      end
   endgenerate

   logic               exec;
   logic               flag_mode;
   logic               wc;
   logic               wz;
   logic               imm;
   bop_e               op;
   logic [FIELD_W-1:0] dst;
   logic [FIELD_W-1:0] src;

   logic [XLEN-1:0]    dst_word;
   logic [XLEN-1:0]    src_word;
   logic [XLEN-1:0]    new_word;
   logic [IW-1:0]      idx;
   logic               c_fold;
   logic               z_fold;
   logic               rnd_bit;
   logic               rnd_step;
   logic               rf_we;
   logic [LFSR_W-1:0]  lfsr_state;
   logic               unused_hi;

   bfx_decode u_dec (
      .instr_valid (instr_valid),
      .ins         (instr_t'(instr)),
      .c           (c_flag),
      .z           (z_flag),
      .exec        (exec),
      .flag_mode   (flag_mode),
      .wc          (wc),
      .wz          (wz),
      .imm         (imm),
      .op          (op),
      .dst         (dst),
      .src         (src)
   );

   bfx_regfile #(
      .XLEN           (XLEN),
      .NREG           (NREG),
      .CLEAR_ON_RESET (CLEAR_ON_RESET)
   ) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (rf_we),
      .waddr   (dst[AW-1:0]),
      .wdata   (new_word),
      .ra_addr (dst[AW-1:0]),
      .ra_data (dst_word),
      .rb_addr (src[AW-1:0]),
      .rb_data (src_word),
      .rc_addr (aux_addr),
      .rc_data (aux_data)
   );

   assign idx       = imm ? src[IW-1:0] : src_word[IW-1:0];
   assign unused_hi = ^src_word[XLEN-1:IW];

   bfx_lfsr #(
      .W    (LFSR_W),
      .SEED (LFSR_SEED),
      .TAPS (LFSR_TAPS)
   ) u_rng (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (rnd_step),
      .bit_out (rnd_bit),
      .state   (lfsr_state)
   );

   bfx_bitop #(.XLEN(XLEN)) u_op (
      .op       (op),
      .word     (dst_word),
      .idx      (idx),
      .c        (c_flag),
      .z        (z_flag),
      .rnd      (rnd_bit),
      .new_word (new_word),
      .c_fold   (c_fold),
      .z_fold   (z_fold)
   );

   assign rf_we    = exec & ~flag_mode;
   assign rnd_step = rf_we & (op == OP_RND);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_flag <= 1'b0;
         z_flag <= 1'b0;
      end else if (exec && flag_mode) begin
         if (wc) c_flag <= c_fold;
         if (wz) z_flag <= z_fold;
      end
   end

endmodule

// File: rtl/bfx_chk.sv
module bfx_chk #(
   parameter int LW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          instr_valid,
   input logic [3:0]    cond,
   input logic [6:0]    opcode,
   input logic          wc,
   input logic          wz,
   input logic          c_flag,
   input logic          z_flag,
   input logic          rf_we,
   input logic [LW-1:0] lfsr_state
);

   logic passes;
   logic foreign;

   assign passes  = cond[{c_flag, z_flag}];
   assign foreign = (opcode[6:3] != 4'b0100);

   p_foreign_no_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      instr_valid && foreign |-> !rf_we);

   p_foreign_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
      instr_valid && foreign |=> $stable(c_flag) && $stable(z_flag));

   p_cond_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      instr_valid && !passes |-> !rf_we);

   p_cond_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
      instr_valid && !passes |=> $stable(c_flag) && $stable(z_flag));

   p_regmode_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
      instr_valid && !wc && !wz |=> $stable(c_flag) && $stable(z_flag));

   p_lfsr_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_state != '0);

   p_flagmode_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      instr_valid && (wc || wz) |-> !rf_we);

   p_c_untouched_r7: assert property (@(posedge clk) disable iff (!rst_n)
      instr_valid && !wc |=> $stable(c_flag));

   p_z_untouched_r7: assert property (@(posedge clk) disable iff (!rst_n)
      instr_valid && !wz |=> $stable(z_flag));

   p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid |-> !rf_we);

   p_idle_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid |=> $stable(c_flag) && $stable(z_flag));

endmodule

bind bitflag_exec bfx_chk #(.LW(LFSR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .instr_valid (instr_valid),
   .cond        (instr[31:28]),
   .opcode      (instr[27:21]),
   .wc          (instr[20]),
   .wz          (instr[19]),
   .c_flag      (c_flag),
   .z_flag      (z_flag),
   .rf_we       (rf_we),
   .lfsr_state  (lfsr_state)
);

// File: tb/sim_bitflag_exec.sv
module sim_bitflag_exec;
   timeunit 1ns;
   timeprecision 1ps;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_valid = 1'b0;
   logic [31:0] instr = '0;
   logic [8:0]  aux_addr = '0;
   logic [31:0] aux_data;
   logic        c_flag;
   logic        z_flag;

   always #2.5 clk = ~clk;

   bitflag_exec u0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .instr_valid (instr_valid),
      .instr       (instr),
      .aux_addr    (aux_addr),
      .aux_data    (aux_data),
      .c_flag      (c_flag),
      .z_flag      (z_flag)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   logic [31:0] mreg [512];
   logic        mc;
   logic        mz;
   logic [15:0] mlfsr;
   logic [31:0] lcg = 32'h1234_5678;

   task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(logic [3:0] cond, logic [6:0] opc, logic wc, logic wz,
                                      logic im, logic [8:0] d, logic [8:0] s);
      return {cond, opc, wc, wz, im, d, s};
   endfunction

   function automatic logic [31:0] rnd32();
      lcg = lcg * 32'd1103515245 + 32'd12345;
      return {lcg[15:0], lcg[31:16]};
   endfunction

   // advance the bench model by one instruction (R1..R8)
   task automatic model(logic [31:0] w, output string tc, output string tz, output string tr);
      logic [3:0] cond;
      logic [6:0] opc;
      logic       wc, wz, im, b, bn, nb, f;
      logic [8:0] d, s;
      logic [4:0] ix;
      logic [31:0] wv;
      cond = w[31:28]; opc = w[27:21]; wc = w[20]; wz = w[19]; im = w[18];
      d = w[17:9]; s = w[8:0];
      if (opc[6:3] != 4'b0100) begin
         tc = "R1"; tz = "R1"; tr = "R1";
         return;
      end
      if (!cond[{mc, mz}]) begin
         tc = "R2"; tz = "R2"; tr = "R2";
         return;
      end
      ix = im ? s[4:0] : mreg[s][4:0];
      wv = mreg[d];
      b  = wv[ix];
      if (wc || wz) begin
         bn = opc[0] ? ~b : b;
         tr = "R5";
         tc = wc ? (wz ? "R6" : "R5") : "R7";
         tz = wz ? (wc ? "R6" : "R5") : "R7";
         if (wc) begin
            f = mc;
            case (opc[2:1])
               2'd0: mc = f & bn;
               2'd1: mc = f | bn;
               2'd2: mc = f ^ bn;
               default: mc = bn;
            endcase
         end
         if (wz) begin
            f = mz;
            case (opc[2:1])
               2'd0: mz = f & bn;
               2'd1: mz = f | bn;
               2'd2: mz = f ^ bn;
               default: mz = bn;
            endcase
         end
      end else begin
         tc = "R3"; tz = "R3";
         tr = (opc[2:0] == 3'd7) ? "R4" : "R3";
         case (opc[2:0])
            3'd0: nb = 1'b0;
            3'd1: nb = 1'b1;
            3'd2: nb = mc;
            3'd3: nb = ~mc;
            3'd4: nb = mz;
            3'd5: nb = ~mz;
            3'd6: nb = ~b;
            default: begin
               nb = mlfsr[0];
               mlfsr = {mlfsr[14:0], mlfsr[15] ^ mlfsr[13] ^ mlfsr[12] ^ mlfsr[10]};
            end
         endcase
         wv[ix] = nb;
         mreg[d] = wv;
      end
   endtask

   task automatic compare(string tc, string tz, string tr, logic [8:0] d);
      aux_addr = d;
      #0.5;
      check(tc, "C flag", {31'b0, c_flag}, {31'b0, mc});
      check(tz, "Z flag", {31'b0, z_flag}, {31'b0, mz});
      check(tr, "dest register", aux_data, mreg[d]);
   endtask

   task automatic run(logic [31:0] w, string force_tag = "");
      string tc, tz, tr;
      model(w, tc, tz, tr);
      if (force_tag != "") begin
         tc = force_tag; tz = force_tag; tr = force_tag;
      end
      @(negedge clk);
      instr = w;
      instr_valid = 1'b1;
      @(negedge clk);
      instr_valid = 1'b0;
      compare(tc, tz, tr, w[17:9]);
   endtask

   initial begin
      #1000000;
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      string tc, tz, tr;
      logic [31:0] w;
      for (int i = 0; i < 512; i++) mreg[i] = '0;
      mc = 1'b0; mz = 1'b0; mlfsr = 16'hACE1;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9, R10: reset state
      check("R9", "C after reset", {31'b0, c_flag}, 32'd0);
      check("R9", "Z after reset", {31'b0, z_flag}, 32'd0);
      aux_addr = 9'd0; #0.5;
      check("R10", "reg 0 after reset", aux_data, 32'd0);
      aux_addr = 9'd511; #0.5;
      check("R10", "reg 511 after reset", aux_data, 32'd0);

      // R4: first random writes follow the LFSR from its seed
      for (int k = 0; k < 32; k++)
         run(mk(4'hF, 7'b0100111, 1'b0, 1'b0, 1'b1, 9'd30, 9'(k)), "R4");

      // mixed instruction stream to fill registers and exercise everything
      for (int n = 0; n < 2000; n++) begin
         logic [31:0] r;
         logic [3:0]  cnd;
         logic [6:0]  opc;
         logic [8:0]  s;
         r   = rnd32();
         cnd = (r[3:0] < 4'd10) ? 4'hF : r[7:4];
         opc = (r[11:8] == 4'd0) ? {3'b011, r[15:12]} : {4'b0100, r[14:12]};
         s   = r[18] ? r[30:22] : {6'b0, r[24:22]};
         run(mk(cnd, opc, r[16], r[17], r[18], {6'b0, r[21:19]}, s));
      end

      // exhaustive sweep: condition x operation x flag-write x index source
      for (int cd = 0; cd < 16; cd++)
         for (int op = 0; op < 8; op++)
            for (int fm = 0; fm < 4; fm++)
               for (int im = 0; im < 2; im++) begin
                  logic [8:0] s;
                  s = (im != 0) ? {4'(op * 3 + cd), 5'(op * 7 + fm * 5 + cd)} : 9'((op + fm) % 8);
                  run(mk(4'(cd), {4'b0100, 3'(op)}, fm[1], fm[0], im[0], 9'((cd + op) % 8), s));
               end

      // R1: opcodes outside the group
      run(mk(4'hF, 7'b0000001, 1'b0, 1'b0, 1'b1, 9'd3, 9'd2), "R1");
      run(mk(4'hF, 7'b0101000, 1'b1, 1'b1, 1'b1, 9'd4, 9'd1), "R1");
      run(mk(4'hF, 7'b1100110, 1'b0, 1'b0, 1'b1, 9'd5, 9'd0), "R1");

      // R8: index taken from a register whose upper bits are set
      run(mk(4'hF, 7'b0100000, 1'b0, 1'b0, 1'b1, 9'd40, 9'd0), "R8");
      for (int k = 1; k < 32; k++)
         run(mk(4'hF, 7'b0100000, 1'b0, 1'b0, 1'b1, 9'd40, 9'(k)), "R8");
      run(mk(4'hF, 7'b0100001, 1'b0, 1'b0, 1'b1, 9'd40, 9'd31), "R8");
      run(mk(4'hF, 7'b0100001, 1'b0, 1'b0, 1'b1, 9'd40, 9'd20), "R8");
      run(mk(4'hF, 7'b0100001, 1'b0, 1'b0, 1'b1, 9'd40, 9'd9), "R8");
      run(mk(4'hF, 7'b0100001, 1'b0, 1'b0, 1'b1, 9'd40, 9'd2), "R8");
      run(mk(4'hF, 7'b0100001, 1'b0, 1'b0, 1'b1, 9'd40, 9'd0), "R8");
      for (int k = 0; k < 32; k++)
         run(mk(4'hF, 7'b0100000, 1'b0, 1'b0, 1'b1, 9'd41, 9'(k)), "R8");
      run(mk(4'hF, 7'b0100001, 1'b0, 1'b0, 1'b1, 9'd41, 9'd5), "R8");
      run(mk(4'hF, 7'b0100110, 1'b1, 1'b0, 1'b0, 9'd41, 9'd40), "R8");
      check("R8", "C from register index", {31'b0, c_flag}, 32'd1);
      run(mk(4'hF, 7'b0100111, 1'b0, 1'b1, 1'b1, 9'd41, 9'b111100101), "R8");
      check("R8", "Z from high-bit immediate", {31'b0, z_flag}, 32'd0);

      // R9: back-to-back issue sees the previous write
      model(mk(4'hF, 7'b0100000, 1'b0, 1'b0, 1'b1, 9'd50, 9'd12), tc, tz, tr);
      model(mk(4'hF, 7'b0100110, 1'b1, 1'b0, 1'b1, 9'd50, 9'd12), tc, tz, tr);
      model(mk(4'hF, 7'b0100001, 1'b0, 1'b0, 1'b1, 9'd50, 9'd12), tc, tz, tr);
      model(mk(4'hF, 7'b0100110, 1'b0, 1'b1, 1'b1, 9'd50, 9'd12), tc, tz, tr);
      @(negedge clk);
      instr = mk(4'hF, 7'b0100000, 1'b0, 1'b0, 1'b1, 9'd50, 9'd12); instr_valid = 1'b1;
      @(negedge clk);
      instr = mk(4'hF, 7'b0100110, 1'b1, 1'b0, 1'b1, 9'd50, 9'd12);
      @(negedge clk);
      instr = mk(4'hF, 7'b0100001, 1'b0, 1'b0, 1'b1, 9'd50, 9'd12);
      @(negedge clk);
      instr = mk(4'hF, 7'b0100110, 1'b0, 1'b1, 1'b1, 9'd50, 9'd12);
      @(negedge clk);
      instr_valid = 1'b0;
      compare("R9", "R9", "R9", 9'd50);
      check("R9", "C after back-to-back", {31'b0, c_flag}, 32'd0);
      check("R9", "Z after back-to-back", {31'b0, z_flag}, 32'd1);

      // R9: idle cycles with a live-looking word change nothing
      w = mk(4'hF, 7'b0100110, 1'b1, 1'b1, 1'b1, 9'd50, 9'd3);
      @(negedge clk);
      instr = w;
      repeat (3) @(negedge clk);
      compare("R9", "R9", "R9", 9'd50);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule